// File: doc/BRIEF.md
# Bus Initialization Signal Sequencer

This block drives the three initialization lines of a backplane bus: a system reset line, an early power-fail warning line (AC low) and a logic-power-fail line (DC low). Each line is an active-high drive bit. A downstream open-collector driver turns it into the bus level. A host issues commands over a valid/ready port. A command can force one line to a chosen level, start a timed reset pulse, or start a simulated power-down/power-up cycle that steps the two power lines through four ordered phases.

All timing is counted in milliseconds. A prescaler of `CLK_PER_MS` clock cycles produces the millisecond tick, so one millisecond of delay is exactly `CLK_PER_MS` cycles. The power cycle has priority over the reset pulse. While the power cycle runs, the reset-pulse timer is frozen. When the power cycle drives DC low, the reset line is released and any running pulse is cancelled, so the system never leaves power-down with reset already set.

Back-pressure rules for the command port: a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ack` is high for exactly the following cycle. `cmd_ready` is low during that acknowledge cycle, so at most one command is taken every two cycles. The host must hold its command stable until it is taken.

Top module: `initsig_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `line_ctrl` to 0 and `busy` to 0, returns both sequences to idle, and leaves `cmd_ready` high.
- R2: Opcode 0 sets one line. `cmd_sel` picks the line by mask: 0x08 is the reset line, `line_ctrl` bit 3; 0x10 is AC low, bit 4; 0x20 is DC low, bit 5. A nonzero `cmd_val` asserts the line and zero releases it. No other line changes. The new level is visible in the cycle after the accepting edge. `line_ctrl` bits 0-2 and 6-7 are always 0.
- R3: Opcode 1 starts a reset pulse. Bit 3 goes high in the cycle after acceptance and stays high for PULSE_MS*CLK_PER_MS cycles.
- R4: An opcode 1 command that arrives while a pulse is running is acknowledged but does not restart or lengthen the pulse.
- R5: Opcode 2 starts a power cycle whose phase length is P = PHASE_MS*CLK_PER_MS cycles. Bit 4 rises in the cycle after acceptance. Bit 5 rises P cycles later. Bit 4 falls 2P cycles after its rise, and bit 5 falls 3P cycles after that rise.
- R6: On the edge where a power cycle asserts bit 5, bit 3 is released and any running reset pulse ends.
- R7: While a power cycle is running, the reset-pulse timer does not advance. A pulse started during the last phase therefore ends PULSE_MS*CLK_PER_MS cycles after bit 5 falls.
- R8: `cmd_ack` is high exactly in the cycle after each accepting edge, and `cmd_ready` is low in that cycle.
- R9: `busy` rises in the cycle after a pulse or power-cycle command starts a sequence. It stays high until the edge that performs the last release of every running sequence.
- R10: Opcode 3, or opcode 0 with a `cmd_sel` other than the three masks, is acknowledged and changes no line.
- R11: An opcode 2 command that arrives while a power cycle is running is acknowledged and ignored; the running phase timing is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may be taken at the next edge |
| cmd_op | input | 2 | 0 set line, 1 reset pulse, 2 power cycle, 3 no action |
| cmd_sel | input | 8 | Line mask for opcode 0 (0x08, 0x10, 0x20) |
| cmd_val | input | 16 | Level for opcode 0; nonzero asserts |
| cmd_ack | output | 1 | One-cycle acknowledge after acceptance |
| line_ctrl | output | 8 | Line drive bits: 3 reset, 4 AC low, 5 DC low |
| busy | output | 1 | A timed sequence is running |

## Verification
Every line change caused by a command is due in the cycle after the accepting edge, and so is the acknowledge. Pulse ends are due PULSE_MS*CLK_PER_MS edges after their start, counted only on edges with no power cycle running. Power-cycle phase edges are due at whole multiples of PHASE_MS*CLK_PER_MS after the start. The bench steps a behavioural model with countdown integers on each rising edge and compares every output on each falling edge, so each result is checked in exactly the cycle it is due. Directed checks then measure rise and fall cycle numbers against the requirement offsets.

// File: rtl/initsig_pkg.sv
package initsig_pkg;

  localparam int LINE_W   = 8;
  localparam int BIT_INIT = 3;
  localparam int BIT_ACLO = 4;
  localparam int BIT_DCLO = 5;
  localparam int NLINES   = 3;

  localparam logic [LINE_W-1:0] SEL_INIT = 8'h08;
  localparam logic [LINE_W-1:0] SEL_ACLO = 8'h10;
  localparam logic [LINE_W-1:0] SEL_DCLO = 8'h20;

  // internal line index order inside the line register
  localparam int IDX_INIT = 0;
  localparam int IDX_ACLO = 1;
  localparam int IDX_DCLO = 2;

  typedef enum logic [1:0] {
    OP_SET_LINE    = 2'd0,
    OP_RESET_PULSE = 2'd1,
    OP_POWER_CYCLE = 2'd2,
    OP_NONE        = 2'd3
  } cmd_op_e;

  typedef enum logic {
    PU_IDLE = 1'b0,
    PU_HOLD = 1'b1
  } pu_state_e;

  typedef enum logic [1:0] {
    PC_IDLE   = 2'd0,
    PC_WAIT_A = 2'd1,  // AC low asserted, waiting
    PC_WAIT_B = 2'd2,  // DC low asserted, waiting
    PC_WAIT_C = 2'd3   // AC low released, waiting
  } pc_state_e;

endpackage

// File: rtl/initsig_ms_timer.sv
module initsig_ms_timer #(
  parameter int CLK_PER_MS = 200000,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            en_i,
  output logic            expire_o
);

  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_PER_MS - 1);

  logic [MS_W-1:0]  ms_q;
  logic [PRE_W-1:0] pre_q;
  logic             running;
  logic             last_cycle;

  assign running    = (ms_q != '0);
  assign last_cycle = (ms_q == MS_W'(1)) && (pre_q == '0);
  assign expire_o   = en_i && last_cycle;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q  <= '0;
      pre_q <= '0;
    end else if (load_i) begin
      ms_q  <= ms_i;
      pre_q <= PRE_TOP;
    end else if (en_i && running) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        ms_q  <= ms_q - MS_W'(1);
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end

  AST_TMR_FROZEN_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !en_i) |=> ($stable(ms_q) && $stable(pre_q))); // R7

  AST_TMR_EMPTY_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !load_i) |=> (ms_q == '0)); // R3

endmodule

// File: rtl/initsig_cmd_port.sv
module initsig_cmd_port
  import initsig_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [LINE_W-1:0]   cmd_sel,
  input  logic [VAL_W-1:0]    cmd_val,
  output logic                cmd_ready,
  output logic                cmd_ack,
  output logic                go_set_o,
  output logic                go_pulse_o,
  output logic                go_pwr_o,
  output logic [NLINES-1:0]   sel_hot_o,
  output logic                level_o
);

  logic    accept;
  logic    ack_q;
  cmd_op_e op;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = !ack_q;
  assign cmd_ack   = ack_q;
  assign accept    = cmd_valid && cmd_ready;

  assign go_set_o   = accept && (op == OP_SET_LINE);
  assign go_pulse_o = accept && (op == OP_RESET_PULSE);
  assign go_pwr_o   = accept && (op == OP_POWER_CYCLE);
  assign level_o    = |cmd_val;

  always_comb begin
    sel_hot_o = '0;
    unique case (cmd_sel)
      SEL_INIT: sel_hot_o[IDX_INIT] = 1'b1;
      SEL_ACLO: sel_hot_o[IDX_ACLO] = 1'b1;
      SEL_DCLO: sel_hot_o[IDX_DCLO] = 1'b1;
      default:  sel_hot_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= accept;
  end

  AST_ACK_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> cmd_ack); // R8

  AST_ACK_ONLY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !cmd_ack); // R8

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_hot_o)); // R2

endmodule

// File: rtl/initsig_pulse_ctl.sv
module initsig_pulse_ctl
  import initsig_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int PULSE_MS   = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic hold_i,
  input  logic abort_i,
  output logic active_o,
  output logic set_init_o,
  output logic clr_init_o
);

  localparam int MS_W = (PULSE_MS > 1) ? $clog2(PULSE_MS + 1) : 1;

  pu_state_e state_q;
  logic      start_ok;
  logic      tmr_en;
  logic      expire;

  assign start_ok   = start_i && (state_q == PU_IDLE) && !abort_i;
  assign tmr_en     = (state_q == PU_HOLD) && !hold_i;
  assign active_o   = (state_q == PU_HOLD);
  assign set_init_o = start_ok;
  assign clr_init_o = expire;

  initsig_ms_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_W       (MS_W)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (start_ok),
    .ms_i     (MS_W'(PULSE_MS)),
    .en_i     (tmr_en),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst)           state_q <= PU_IDLE;
    else if (abort_i)  state_q <= PU_IDLE;
    else if (start_ok) state_q <= PU_HOLD;
    else if (expire)   state_q <= PU_IDLE;
  end

  AST_PULSE_FROZEN_IN_PWR: assert property (@(posedge clk) disable iff (rst)
    ((state_q == PU_HOLD) && hold_i && !abort_i) |=> (state_q == PU_HOLD)); // R7

  AST_PULSE_ABORT_IDLES: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (state_q == PU_IDLE)); // R6

endmodule

// File: rtl/initsig_pwr_ctl.sv
module initsig_pwr_ctl
  import initsig_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int PHASE_MS   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o,
  output logic set_aclo_o,
  output logic set_dclo_o,
  output logic clr_aclo_o,
  output logic clr_dclo_o
);

  localparam int MS_W = (PHASE_MS > 1) ? $clog2(PHASE_MS + 1) : 1;

  pc_state_e state_q;
  logic      start_ok;
  logic      expire;
  logic      reload;

  assign start_ok = start_i && (state_q == PC_IDLE);
  assign active_o = (state_q != PC_IDLE);
  assign reload   = start_ok || (expire && (state_q != PC_WAIT_C));

  assign set_aclo_o = start_ok;
  assign set_dclo_o = expire && (state_q == PC_WAIT_A);
  assign clr_aclo_o = expire && (state_q == PC_WAIT_B);
  assign clr_dclo_o = expire && (state_q == PC_WAIT_C);

  initsig_ms_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_W       (MS_W)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (reload),
    .ms_i     (MS_W'(PHASE_MS)),
    .en_i     (active_o),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PC_IDLE;
    end else begin
      unique case (state_q)
        PC_IDLE:   if (start_ok) state_q <= PC_WAIT_A;
        PC_WAIT_A: if (expire)   state_q <= PC_WAIT_B;
        PC_WAIT_B: if (expire)   state_q <= PC_WAIT_C;
        PC_WAIT_C: if (expire)   state_q <= PC_IDLE;
        default:                 state_q <= PC_IDLE;
      endcase
    end
  end

  AST_PC_ORDER_A: assert property (@(posedge clk) disable iff (rst)
    (state_q == PC_WAIT_A) |=> (state_q == PC_WAIT_A || state_q == PC_WAIT_B)); // R5

  AST_PC_ORDER_B: assert property (@(posedge clk) disable iff (rst)
    (state_q == PC_WAIT_B) |=> (state_q == PC_WAIT_B || state_q == PC_WAIT_C)); // R5

  AST_PC_ORDER_C: assert property (@(posedge clk) disable iff (rst)
    (state_q == PC_WAIT_C) |=> (state_q == PC_WAIT_C || state_q == PC_IDLE)); // R5

  AST_PC_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start_i && (state_q == PC_WAIT_B)) |=> (state_q != PC_WAIT_A)); // R11

endmodule

// File: rtl/initsig_sequencer.sv
module initsig_sequencer
  import initsig_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int PULSE_MS   = 250,
  parameter int PHASE_MS   = 100,
  parameter int VAL_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_sel,
  input  logic [VAL_W-1:0]  cmd_val,
  output logic              cmd_ack,
  output logic [7:0]        line_ctrl,
  output logic              busy
);

  logic              go_set, go_pulse, go_pwr, level;
  logic [NLINES-1:0] sel_hot;
  logic              pu_active, pu_set_init, pu_clr_init;
  logic              pc_active, pc_set_aclo, pc_set_dclo, pc_clr_aclo, pc_clr_dclo;
  logic [NLINES-1:0] line_q, line_d;

  initsig_cmd_port #(.VAL_W(VAL_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_sel    (cmd_sel),
    .cmd_val    (cmd_val),
    .cmd_ready  (cmd_ready),
    .cmd_ack    (cmd_ack),
    .go_set_o   (go_set),
    .go_pulse_o (go_pulse),
    .go_pwr_o   (go_pwr),
    .sel_hot_o  (sel_hot),
    .level_o    (level)
  );

  initsig_pulse_ctl #(.CLK_PER_MS(CLK_PER_MS), .PULSE_MS(PULSE_MS)) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .start_i    (go_pulse),
    .hold_i     (pc_active),
    .abort_i    (pc_set_dclo),
    .active_o   (pu_active),
    .set_init_o (pu_set_init),
    .clr_init_o (pu_clr_init)
  );

  initsig_pwr_ctl #(.CLK_PER_MS(CLK_PER_MS), .PHASE_MS(PHASE_MS)) u_pwr (
    .clk        (clk),
    .rst        (rst),
    .start_i    (go_pwr),
    .active_o   (pc_active),
    .set_aclo_o (pc_set_aclo),
    .set_dclo_o (pc_set_dclo),
    .clr_aclo_o (pc_clr_aclo),
    .clr_dclo_o (pc_clr_dclo)
  );

  // Precedence: host level write, then pulse events, then power-cycle events.
  always_comb begin
    line_d = line_q;
    for (int i = 0; i < NLINES; i++) begin
      if (go_set && sel_hot[i]) line_d[i] = level;
    end
    if (pu_set_init) line_d[IDX_INIT] = 1'b1;
    if (pu_clr_init) line_d[IDX_INIT] = 1'b0;
    if (pc_set_aclo) line_d[IDX_ACLO] = 1'b1;
    if (pc_clr_aclo) line_d[IDX_ACLO] = 1'b0;
    if (pc_set_dclo) begin
      line_d[IDX_DCLO] = 1'b1;
      line_d[IDX_INIT] = 1'b0;
    end
    if (pc_clr_dclo) line_d[IDX_DCLO] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_d;
  end

  always_comb begin
    line_ctrl           = '0;
    line_ctrl[BIT_INIT] = line_q[IDX_INIT];
    line_ctrl[BIT_ACLO] = line_q[IDX_ACLO];
    line_ctrl[BIT_DCLO] = line_q[IDX_DCLO];
  end

  assign busy = pu_active || pc_active;

  AST_DCLO_DROPS_INIT: assert property (@(posedge clk) disable iff (rst)
    pc_set_dclo |=> (line_ctrl[BIT_DCLO] && !line_ctrl[BIT_INIT])); // R6

  AST_PWR_START_ACLO: assert property (@(posedge clk) disable iff (rst)
    pc_set_aclo |=> (line_ctrl[BIT_ACLO] && busy)); // R5

  AST_PULSE_END_INIT: assert property (@(posedge clk) disable iff (rst)
    pu_clr_init |=> !line_ctrl[BIT_INIT]); // R3

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $countones(line_ctrl & 8'hC7) == 0); // R2

endmodule

// File: tb/initsig_sequencer_tb.sv
`timescale 1ns/1ps
module initsig_sequencer_tb;

  localparam int CPM = 4;
  localparam int PMS = 5;
  localparam int HMS = 3;
  localparam int PW  = PMS * CPM;
  localparam int PH  = HMS * CPM;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_sel = 8'h00;
  logic [15:0] cmd_val = 16'h0;
  logic        cmd_ack;
  logic [7:0]  line_ctrl;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  initsig_sequencer #(.CLK_PER_MS(CPM), .PULSE_MS(PMS), .PHASE_MS(HMS), .VAL_W(16)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_val(cmd_val), .cmd_ack(cmd_ack),
    .line_ctrl(line_ctrl), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_line = 8'h00;
  bit m_ack = 0, p_act = 0;
  int p_cnt = 0, pc_ph = 0, pc_cnt = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_line = 8'h00; m_ack = 0; p_act = 0; p_cnt = 0; pc_ph = 0; pc_cnt = 0;
    end else begin
      bit acc, p_exp, p_start;
      int pc_ev;
      acc = cmd_valid && !m_ack;
      p_exp = 0; pc_ev = 0;
      if (p_act && pc_ph == 0) begin
        p_cnt--;
        if (p_cnt == 0) p_exp = 1;
      end
      if (pc_ph != 0) begin
        pc_cnt--;
        if (pc_cnt == 0) pc_ev = pc_ph;
      end
      if (acc && cmd_op == 2'd0) begin
        if (cmd_sel == 8'h08) m_line[3] = (cmd_val != 0);
        if (cmd_sel == 8'h10) m_line[4] = (cmd_val != 0);
        if (cmd_sel == 8'h20) m_line[5] = (cmd_val != 0);
      end
      p_start = acc && cmd_op == 2'd1 && !p_act && pc_ev != 1;
      if (p_exp) begin p_act = 0; m_line[3] = 0; end
      if (p_start) begin p_act = 1; p_cnt = PW; m_line[3] = 1; end
      if (acc && cmd_op == 2'd2 && pc_ph == 0) begin
        pc_ph = 1; pc_cnt = PH; m_line[4] = 1;
      end
      case (pc_ev)
        1: begin m_line[5] = 1; m_line[3] = 0; p_act = 0; pc_ph = 2; pc_cnt = PH; end
        2: begin m_line[4] = 0; pc_ph = 3; pc_cnt = PH; end
        3: begin m_line[5] = 0; pc_ph = 0; end
        default: ;
      endcase
      m_ack = acc;
    end
  end

  // per-cycle comparison and edge monitor
  int rise_at[4];
  int fall_at[4];
  logic [3:0] prev_mon = 4'h0;

  always @(negedge clk) begin
    logic [3:0] mon;
    chk("R2 R3 R5 R6 R7 line_ctrl vs model", line_ctrl, m_line);
    chk("R9 busy vs model", busy, (p_act || pc_ph != 0));
    chk("R8 ack vs model", cmd_ack, m_ack);
    chk("R8 ready vs model", cmd_ready, !m_ack);
    mon = {busy, line_ctrl[5], line_ctrl[4], line_ctrl[3]};
    for (int k = 0; k < 4; k++) begin
      if (mon[k] && !prev_mon[k]) rise_at[k] = cyc;
      if (!mon[k] && prev_mon[k]) fall_at[k] = cyc;
    end
    prev_mon = mon;
  end

  task automatic send(input logic [1:0] op, input logic [7:0] sel, input logic [15:0] val);
    cmd_op = op; cmd_sel = sel; cmd_val = val; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 ack after accept", cmd_ack, 1'b1);
    chk("R8 ready low in ack cycle", cmd_ready, 1'b0);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 400 && busy; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", line_ctrl, 8'h00);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset ready", cmd_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);

    // R2 direct level writes
    send(2'd0, 8'h10, 16'h0005); chk("R2 set ac-low", line_ctrl, 8'h10);
    send(2'd0, 8'h20, 16'h0100); chk("R2 set dc-low", line_ctrl, 8'h30);
    send(2'd0, 8'h08, 16'h0001); chk("R2 set reset line", line_ctrl, 8'h38);
    send(2'd0, 8'h10, 16'h0000); chk("R2 release ac-low", line_ctrl, 8'h28);
    send(2'd0, 8'h08, 16'h0000); chk("R2 release reset line", line_ctrl, 8'h20);
    send(2'd0, 8'h20, 16'h0000); chk("R2 release dc-low", line_ctrl, 8'h00);

    // R10 ignored commands
    send(2'd0, 8'h18, 16'h0001); chk("R10 bad select no change", line_ctrl, 8'h00);
    send(2'd0, 8'h01, 16'h0001); chk("R10 spare select no change", line_ctrl, 8'h00);
    send(2'd3, 8'h08, 16'h0001); chk("R10 op3 no change", line_ctrl, 8'h00);
    chk("R10 op3 not busy", busy, 1'b0);

    // R3 pulse width, R9 busy span
    send(2'd1, 8'h00, 16'h0);
    chk("R3 pulse up", line_ctrl, 8'h08);
    wait_idle();
    chk("R3 pulse width", fall_at[0] - rise_at[0], PW);
    chk("R9 busy span pulse", fall_at[3] - rise_at[3], PW);

    // R4 re-issue during pulse
    send(2'd1, 8'h00, 16'h0);
    repeat (8) @(negedge clk);
    send(2'd1, 8'h00, 16'h0);
    wait_idle();
    chk("R4 no restart width", fall_at[0] - rise_at[0], PW);

    // R5 phase order, R11 re-issue ignored
    send(2'd2, 8'h00, 16'h0);
    chk("R5 ac-low first", line_ctrl, 8'h10);
    repeat (5) @(negedge clk);
    send(2'd2, 8'h00, 16'h0);
    wait_idle();
    chk("R5 dc-low rise offset", rise_at[2] - rise_at[1], PH);
    chk("R5 ac-low fall offset", fall_at[1] - rise_at[1], 2 * PH);
    chk("R5 dc-low fall offset", fall_at[2] - rise_at[1], 3 * PH);
    chk("R11 span unchanged", fall_at[3] - rise_at[3], 3 * PH);

    // R6 dc-low cancels a running pulse
    send(2'd1, 8'h00, 16'h0);
    repeat (3) @(negedge clk);
    send(2'd2, 8'h00, 16'h0);
    wait_idle();
    chk("R6 reset released with dc-low", fall_at[0], rise_at[2]);
    chk("R6 reset stays low", line_ctrl, 8'h00);

    // R6 also releases a directly set reset line
    send(2'd0, 8'h08, 16'h0001);
    send(2'd2, 8'h00, 16'h0);
    wait_idle();
    chk("R6 direct reset released", fall_at[0], rise_at[2]);

    // R7 pulse frozen during last power phase
    send(2'd2, 8'h00, 16'h0);
    for (int n = 0; n < 200 && !line_ctrl[5]; n++) @(negedge clk);
    for (int n = 0; n < 200 && line_ctrl[4]; n++) @(negedge clk);
    send(2'd1, 8'h00, 16'h0);
    chk("R7 pulse up during power cycle", line_ctrl, 8'h28);
    wait_idle();
    chk("R7 pulse end after power cycle", fall_at[0] - fall_at[2], PW);

    // R1 reset in the middle of a power cycle
    send(2'd2, 8'h00, 16'h0);
    repeat (15) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid-sequence reset lines", line_ctrl, 8'h00);
    chk("R1 mid-sequence reset busy", busy, 1'b0);
    chk("R1 mid-sequence reset ready", cmd_ready, 1'b1);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 stays idle after reset", {busy, line_ctrl}, 9'h000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule